// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the clocked front end of a small on-chip synchronous SRAM. On every rising clock edge it samples three chip-select inputs, two address strobes and the write controls, and it picks one of four actions: do nothing, deselect, read one word, or write a chosen set of byte lanes. The word address for each cycle comes from a separate burst sequencer. A separate tag comparator may use the read data. Each word holds two 9-bit lanes, and the top bit of each lane is that lane's parity bit.

Read data leaves the block on a split bus: a data output, plus an enable that tells the pad logic when to drive. The block has two latency modes. In flow-through mode the word appears in the cycle right after the command edge. In pipelined mode it appears one edge later. A deselect passes through the same pipeline as a read, so in pipelined mode the bus stays on until the second edge after the deselect. An output-enable input gates the bus enable without waiting for a clock. A sleep input freezes the command path, and the stored data is kept.

Top module: `sbsram_ctrl`

## Requirements
- R1: The block counts as selected only when ce1_n=0, ce2=1 and ce3_n=0. A strobe cycle that is not selected is a deselect: nothing is read or written and the burst ends. A strobe cycle is one with adsc_n=0, or with adsp_n=0 and ce1_n=0.
- R2: When adsp_n=0 and the block is selected, a read starts at that edge whatever the write inputs are, and no lane is written.
- R3: The write lanes are decoded as follows. gw_n=0 writes both lanes. Otherwise bwe_n=0 writes lane k for each bw_n[k]=0. Otherwise (gw_n=1 and bwe_n=1) the cycle is a read. A selected adsc_n=0 start uses this decode at its own edge.
- R4: Lane k is bits [9k+8:9k] of din and dout, and its parity bit is bit 9k+8. bw_n[k] selects lane k only, and a lane write leaves the other lane unchanged.
- R5: With pipe_mode=0, a word read at edge t is on dout with dout_en=1 (given oe_n=0) from edge t until edge t+1.
- R6: With pipe_mode=1, a word read at edge t is on dout with dout_en=1 (given oe_n=0) from edge t+1 until edge t+2.
- R7: With pipe_mode=1, any cycle without a read at edge t (deselect, write, idle or sleep) turns dout_en off only at edge t+1, after one full cycle.
- R8: oe_n=1 forces dout_en to 0 at once, with no clock edge needed. oe_n=0 lets the pipeline's drive state through.
- R9: While sleep=1, edges start no read and no write, the burst state is held, and the stored words are kept.
- R10: A cycle with no strobe continues an active burst, reading or writing at addr by the R3 decode. When no burst is active, such a cycle does nothing.
- R11: While rst_n=0, dout_en is 0 and no command is taken. After reset no burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 selects pipelined output, 0 selects flow-through |
| sleep | input | 1 | 1 freezes command handling and keeps the contents |
| ce1_n | input | 1 | Active-low chip select that also gates adsp_n |
| ce2 | input | 1 | Active-high chip select |
| ce3_n | input | 1 | Active-low chip select |
| adsp_n | input | 1 | Strobe that always starts a read when selected |
| adsc_n | input | 1 | Strobe that starts a read or a write |
| gw_n | input | 1 | Write both lanes |
| bwe_n | input | 1 | Enable lane writes through bw_n |
| bw_n | input | LANES | Active-low lane selects |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address for this cycle |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | High when dout should be driven onto the pads |

## Verification
The properties assume that pipe_mode changes only while rst_n is low, and that every input is steady around the rising edge. The exception is oe_n, whose effect is checked at the output as soon as it changes. The bench drives every input at the falling edge and changes the mode only inside a reset pulse. The random traffic mixes strobes, chip selects, write decodes, sleep and output-enable freely within those limits.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } sbc_op_e;

  // All three selects must agree before the block responds to a strobe.
  function automatic logic chip_selected(input logic ce1_n, input logic ce2,
                                         input logic ce3_n);
    return !ce1_n && ce2 && !ce3_n;
  endfunction

endpackage

// File: rtl/sbc_cmd_decode.sv
module sbc_cmd_decode
  import sbc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             hold,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             burst_q,
  output sbc_op_e          op,
  output logic [LANES-1:0] lanes,
  output logic             burst_d
);

  // Lane decode: the global write wins, then the per-lane selects.
  function automatic logic [LANES-1:0] lane_mask(input logic g_n, input logic e_n,
                                                 input logic [LANES-1:0] b_n);
    if (!g_n) return '1;
    if (!e_n) return ~b_n;
    return '0;
  endfunction

  logic             p_start;
  logic             c_start;
  logic             sel;
  logic [LANES-1:0] req_lanes;

  always_comb begin
    p_start   = !adsp_n && !ce1_n;
    c_start   = !adsc_n;
    sel       = chip_selected(ce1_n, ce2, ce3_n);
    req_lanes = lane_mask(gw_n, bwe_n, bw_n);
    op        = OP_IDLE;
    lanes     = '0;
    burst_d   = burst_q;
    if (!hold) begin
      if (p_start) begin
        if (sel) begin
          op      = OP_READ;
          burst_d = 1'b1;
        end else begin
          op      = OP_DESEL;
          burst_d = 1'b0;
        end
      end else if (c_start) begin
        if (sel) begin
          burst_d = 1'b1;
          if (|req_lanes) begin
            op    = OP_WRITE;
            lanes = req_lanes;
          end else begin
            op = OP_READ;
          end
        end else begin
          op      = OP_DESEL;
          burst_d = 1'b0;
        end
      end else if (burst_q) begin
        if (|req_lanes) begin
          op    = OP_WRITE;
          lanes = req_lanes;
        end else begin
          op = OP_READ;
        end
      end
    end
  end

endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)       rd_q        <= cells[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sbc_out_pipe.sv
module sbc_out_pipe #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pipe_mode,
  input  logic         rd_issued,
  input  logic [W-1:0] s1_data,
  output logic         drive,
  output logic [W-1:0] bus_data
);

  logic         v1_q;
  logic         v2_q;
  logic [W-1:0] d2_q;

  // Every command cycle enters the valid chain, so a deselect shifts out at
  // the same rate as a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= rd_issued;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    d2_q <= s1_data;
  end

  assign drive    = pipe_mode ? v2_q : v1_q;
  assign bus_data = pipe_mode ? d2_q : s1_data;

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              sleep,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);

  logic             hold;
  sbc_op_e          op;
  logic [LANES-1:0] wr_lanes;
  logic             burst_d;
  logic             burst_q;
  logic             rd_go;
  logic             drive;
  logic [WORD_W-1:0] rd_data;

  assign hold  = sleep || !rst_n;
  assign rd_go = (op == OP_READ);

  sbc_cmd_decode #(.LANES(LANES)) dec_i (
    .hold    (hold),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .burst_q (burst_q),
    .op      (op),
    .lanes   (wr_lanes),
    .burst_d (burst_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_q <= 1'b0;
    else        burst_q <= burst_d;
  end

  sbc_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) mem_i (
    .clk      (clk),
    .rd_en    (rd_go),
    .wr_lanes (wr_lanes),
    .addr     (addr),
    .wdata    (din),
    .rdata    (rd_data)
  );

  sbc_out_pipe #(.W(WORD_W)) pipe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .rd_issued (rd_go),
    .s1_data   (rd_data),
    .drive     (drive),
    .bus_data  (dout)
  );

  assign dout_en = drive && !oe_n;

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pipe_mode,
  input logic             sleep,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             adsp_n,
  input logic             adsc_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic             oe_n,
  input logic             dout_en,
  input logic             rd_go,
  input logic [LANES-1:0] wr_lanes,
  input logic             burst_q,
  input logic             drive
);

  logic sel_all;
  logic strobe_any;
  assign sel_all    = !ce1_n && ce2 && !ce3_n;
  assign strobe_any = !adsc_n || (!adsp_n && !ce1_n);

  // R1: a strobe without full selection does no access
  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe_any && !sel_all) |-> (!rd_go && wr_lanes == '0));

  // R2: a selected address-strobe-P start is always a read
  p_adsp_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adsp_n && sel_all) |-> (rd_go && wr_lanes == '0));

  // R3: global write covers all lanes
  p_gw_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lanes != '0 && !gw_n) |-> (&wr_lanes));

  // R3: with neither write enable low, no lane is written
  p_no_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |-> (wr_lanes == '0));

  // R5: flow-through drives in the cycle after the read edge
  p_flow_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_go) |=> drive);

  // R6: pipelined mode adds one edge
  p_pipe_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_go) |=> ##1 drive);

  // R7: a non-read cycle removes the drive only after the second edge
  p_dcd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !rd_go) |=> ##1 !drive);

  // R8: output enable high blocks the bus
  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R9: sleep blocks all accesses
  p_sleep_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rd_go && wr_lanes == '0));

  // R9: sleep keeps the burst state
  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(burst_q));

  // R10: no strobe and no burst means no access
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strobe_any && !burst_q) |-> (!rd_go && wr_lanes == '0));

endmodule

bind sbsram_ctrl sbc_checker #(.LANES(LANES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pipe_mode (pipe_mode),
  .sleep     (sleep),
  .ce1_n     (ce1_n),
  .ce2       (ce2),
  .ce3_n     (ce3_n),
  .adsp_n    (adsp_n),
  .adsc_n    (adsc_n),
  .gw_n      (gw_n),
  .bwe_n     (bwe_n),
  .oe_n      (oe_n),
  .dout_en   (dout_en),
  .rd_go     (rd_go),
  .wr_lanes  (wr_lanes),
  .burst_q   (burst_q),
  .drive     (drive)
);

// File: tb/sbsram_ctrl_tb_top.sv
module sbsram_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pipe_mode = 1'b0;
  logic        sleep = 1'b0;
  logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic        adsp_n = 1'b1, adsc_n = 1'b1;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [1:0]  bw_n = 2'b11;
  logic        oe_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        dout_en;

  int n_chk = 0;
  int n_bad = 0;

  // bench reference state
  logic [17:0] m_mem [64];
  bit          m_burst = 0, m_v1 = 0, m_v2 = 0;
  logic [17:0] m_d1 = '0, m_d2 = '0;

  always #5 clk = ~clk;

  sbsram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sleep(sleep),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [1:0] exp_lanes(input logic g, input logic e, input logic [1:0] b);
    if (g == 1'b0) return 2'b11;
    if (e == 1'b0) return {~b[1], ~b[0]};
    return 2'b00;
  endfunction

  function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] nw,
                                        input logic [1:0] ln);
    logic [17:0] r;
    r = old;
    if (ln[0]) r[8:0]  = nw[8:0];
    if (ln[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  task automatic check(input string tag);
    bit          ee;
    logic [17:0] ed;
    ee = (pipe_mode ? m_v2 : m_v1) && !oe_n;
    ed = pipe_mode ? m_d2 : m_d1;
    n_chk++;
    if (dout_en !== ee) begin
      n_bad++;
      $display("FAIL %s dout_en=%b expected=%b at %0t", tag, dout_en, ee, $time);
    end else if (ee && dout !== ed) begin
      n_bad++;
      $display("FAIL %s dout=%h expected=%h at %0t", tag, dout, ed, $time);
    end
  endtask

  // Called just after a falling edge with inputs set; ends after the next one.
  task automatic step(input string tag);
    bit          sel, nv1, nb, wr;
    logic [1:0]  ln;
    logic [17:0] nd1;
    logic [5:0]  a;
    logic [17:0] d;
    nv1 = 0; nb = m_burst; wr = 0; nd1 = m_d1;
    a = addr; d = din;
    ln  = exp_lanes(gw_n, bwe_n, bw_n);
    sel = !ce1_n && ce2 && !ce3_n;
    if (!sleep) begin
      if (!adsp_n && !ce1_n) begin
        nb = sel;
        nv1 = sel;
      end else if (!adsc_n) begin
        nb = sel;
        if (sel) begin
          if (ln != 2'b00) wr = 1; else nv1 = 1;
        end
      end else if (m_burst) begin
        if (ln != 2'b00) wr = 1; else nv1 = 1;
      end
    end
    if (nv1) nd1 = m_mem[a];
    @(posedge clk);
    #1;
    m_v2 = m_v1; m_d2 = m_d1;
    m_v1 = nv1;  m_d1 = nd1;
    m_burst = nb;
    if (wr) m_mem[a] = merge(m_mem[a], d, ln);
    @(negedge clk);
    check(tag);
  endtask

  task automatic put(input bit p_n, input bit c_n, input bit e1n, input bit e2,
                     input bit e3n, input bit g_n, input bit be_n, input logic [1:0] b_n,
                     input logic [5:0] a, input logic [17:0] d);
    adsp_n = p_n; adsc_n = c_n; ce1_n = e1n; ce2 = e2; ce3_n = e3n;
    gw_n = g_n; bwe_n = be_n; bw_n = b_n; addr = a; din = d;
  endtask

  task automatic go_idle();
    put(1, 1, 1, 0, 1, 1, 1, 2'b11, '0, '0);
    sleep = 0; oe_n = 0;
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 0; go_idle(); pipe_mode = mode;
    repeat (3) @(negedge clk);
    n_chk++;
    if (dout_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 dout_en=%b expected=0 in reset", dout_en);
    end
    m_v1 = 0; m_v2 = 0; m_burst = 0;
    rst_n = 1;
    step("R11");
  endtask

  task automatic read_back(input logic [5:0] a, input string tag);
    put(1, 0, 0, 1, 0, 1, 1, 2'b11, a, '0);
    step(tag);
    go_idle();
    step(tag);
    step(tag);
  endtask

  task automatic directed();
    // R4/R3: lane 0 only, then lane 1 only via separate selects
    put(1, 0, 0, 1, 0, 1, 0, 2'b10, 6'd3, 18'h3_FFFF); step("R4");
    put(1, 0, 0, 1, 0, 1, 0, 2'b01, 6'd4, 18'h2_AAAA); step("R4");
    put(1, 0, 0, 1, 0, 1, 0, 2'b00, 6'd5, 18'h1_5555); step("R3");
    go_idle(); step("R3");
    read_back(6'd3, "R4"); read_back(6'd4, "R4"); read_back(6'd5, "R3");
    // R2: selected adsp start with global write low must only read
    put(0, 1, 0, 1, 0, 0, 0, 2'b00, 6'd7, 18'h0_1234); step("R2");
    go_idle(); step("R2"); step("R2");
    read_back(6'd7, "R2");
    // R1: start a burst, then an unselected strobe ends it; R10: later idle cycle writes nothing
    put(1, 0, 0, 1, 0, 1, 1, 2'b11, 6'd8, '0); step("R10");
    put(1, 1, 0, 1, 0, 1, 1, 2'b11, 6'd9, '0); step("R10");
    put(1, 0, 0, 0, 0, 1, 1, 2'b11, 6'd9, '0); step("R1");
    put(1, 1, 0, 1, 0, 0, 1, 2'b11, 6'd9, 18'h0_0BAD); step("R10");
    go_idle(); step("R1"); step("R1");
    read_back(6'd9, "R10");
    // R7: read followed by deselect; drive must persist one cycle in pipelined mode
    put(1, 0, 0, 1, 0, 1, 1, 2'b11, 6'd10, '0); step("R7");
    put(1, 0, 1, 1, 0, 1, 1, 2'b11, 6'd10, '0); step("R7");
    go_idle(); step("R7"); step("R7");
    // R9: sleep with a write command leaves contents and state unchanged
    sleep = 1;
    put(1, 0, 0, 1, 0, 0, 1, 2'b11, 6'd11, 18'h2_0C0C); step("R9");
    step("R9");
    sleep = 0; go_idle(); step("R9"); step("R9");
    read_back(6'd11, "R9");
    // R8: output enable acts between edges
    put(1, 0, 0, 1, 0, 1, 1, 2'b11, 6'd12, '0); step("R8");
    go_idle(); step("R8");
    #2 oe_n = 1; #1;
    n_chk++;
    if (dout_en !== 1'b0) begin
      n_bad++; $display("FAIL R8 dout_en=%b expected=0 with oe_n high", dout_en);
    end
    oe_n = 0; #1;
    n_chk++;
    if (dout_en !== (pipe_mode ? m_v2 : m_v1)) begin
      n_bad++; $display("FAIL R8 dout_en=%b expected=%b after oe_n low", dout_en,
                        pipe_mode ? m_v2 : m_v1);
    end
    @(negedge clk);
    step("R8");
  endtask

  task automatic random_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      adsp_n = ($urandom % 4) != 0;
      adsc_n = ($urandom % 4) != 0;
      ce1_n  = ($urandom % 8) == 0;
      ce2    = ($urandom % 8) != 0;
      ce3_n  = ($urandom % 8) == 0;
      gw_n   = ($urandom % 8) != 0;
      bwe_n  = ($urandom % 2) != 0;
      bw_n   = 2'($urandom);
      oe_n   = ($urandom % 8) == 0;
      sleep  = ($urandom % 16) == 0;
      addr   = 6'($urandom);
      din    = 18'($urandom);
      step(tag);
    end
    go_idle();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    do_reset(1'b0);
    // fill the array so every read has a known value
    for (int k = 0; k < 64; k++) begin
      put(1, 0, 0, 1, 0, 0, 1, 2'b11, 6'(k), 18'(k * 4099 + 17));
      step("R3");
    end
    go_idle(); step("R10");
    directed();
    random_run(1500, "R5");
    do_reset(1'b1);
    directed();
    random_run(1500, "R6");
    finish_run();
  end

endmodule